// File: doc/BRIEF.md
# Internal Data Memory Address Decoder

This block turns the operand address of an 8-bit microcontroller core into a physical location. It takes the access mode, the address (a byte address, a pointer value or a bit number), the register number and the two bank-select bits. It returns three things: which storage region is hit (lower RAM, upper RAM or special function registers), the byte index inside that region, and, for bit accesses, the bit position inside the byte.

Direct and indirect accesses share the range 80H–FFH, but they land in different spaces. A direct access there reaches the special function registers. An indirect access there reaches the upper 128 bytes of RAM. Register-mode accesses are remapped into one of four 8-byte banks. Bit numbers are remapped either onto the bit-addressable RAM bytes or onto the special function registers whose address is a multiple of eight.

The block also holds the stack pointer. A push increments it before the write, and a pop reads before it decrements. The stack location is always decoded with indirect rules. A parameter states whether upper RAM exists. When it does not, any access that would land there raises an invalid flag, so the caller can drop a write or treat a read as undefined.

Top module: `idm_decoder`

## Requirements
- R1: In direct mode (acc_mode=0), an address below 80H gives region 0 (lower RAM) with index addr[6:0]. An address of 80H or above gives region 2 (special function registers) with index addr[6:0].
- R2: In indirect mode (acc_mode=1), an address below 80H gives region 0 with index addr[6:0]. An address of 80H or above gives region 1 (upper RAM) with index addr[6:0]. An indirect access never gives region 2.
- R3: `invalid` is 1 exactly when the access lands in region 1 and the parameter HAS_UPPER is 0. It is 0 in every other case, including every access when HAS_UPPER is 1.
- R4: In register mode (acc_mode=2), the region is 0 and the index is bank_sel*8 + reg_num, which lies in 00H–1FH.
- R5: `ptr_idx` gives the lower-RAM location of the indirect pointer. It is bank_sel*8 + reg_num[0], so only R0 or R1 of the selected bank can act as the pointer.
- R6: In bit mode (acc_mode=3), a bit number b below 80H gives region 0 with index 20H + (b >> 3).
- R7: In bit mode, a bit number b of 80H or above gives region 2 with index (b & F8H) - 80H, so the low three bits of the index are zero.
- R8: `bit_pos` equals addr[2:0] in bit mode and 0 in all other modes.
- R9: After reset, `sp` is 07H. When sp_wr is high at a clock edge, sp_din is loaded. This load takes priority over push and pop.
- R10: While push is high, the stack location is sp+1 (wrapping from FFH to 00H). On the clock edge, sp increments.
- R11: While pop is high and push is low, the stack location is sp. On the clock edge, sp decrements.
- R12: The stack location is decoded with the indirect rules of R2. `stk_invalid` follows R3 for that location.
- R13: When push and pop are high together (without sp_wr), the push takes effect and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| addr | input | 8 | Byte address, pointer value or bit number |
| reg_num | input | 3 | Register number within the bank |
| bank_sel | input | 2 | Register bank select bits |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| sp_wr | input | 1 | Load the stack pointer |
| sp_din | input | 8 | Stack pointer load value |
| region | output | 2 | 0 lower RAM, 1 upper RAM, 2 special function registers |
| byte_idx | output | 7 | Byte index inside the region |
| bit_pos | output | 3 | Bit position for bit accesses |
| ptr_idx | output | 5 | Lower-RAM location of the R0/R1 pointer |
| invalid | output | 1 | Access hits upper RAM that is not present |
| sp | output | 8 | Stack pointer |
| stk_region | output | 2 | Region of the current stack location |
| stk_idx | output | 7 | Index of the current stack location |
| stk_invalid | output | 1 | Stack location hits upper RAM that is not present |

## Verification
The bench builds two copies of the block side by side and drives them with the same inputs. One copy has HAS_UPPER=1 and the other has HAS_UPPER=0. This puts the invalid flag under test both where it must stay low and where it must rise.

The decode is swept exhaustively: every mode, every 8-bit address, every bank and every register number, with expected results computed arithmetically. The stack pointer is then loaded to the corners (07H, 7FH, 80H, FFH, 00H), so the test covers wrap-around and stacks crossing into upper RAM.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int AW       = 8;
  localparam int IW       = AW - 1;
  localparam int BP_W     = 3;
  localparam int BANK_W   = 2;
  localparam int RN_W     = 3;
  localparam int PTR_W    = BANK_W + RN_W;
  localparam logic [IW-1:0] BIT_RAM_BASE = 7'h20;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_REGISTER = 2'd2,
    AM_BIT      = 2'd3
  } acc_mode_t;

  typedef enum logic [1:0] {
    RG_LOWER = 2'd0,
    RG_UPPER = 2'd1,
    RG_SFR   = 2'd2
  } region_t;

  // Region reached by a pointer-based (indirect) access.
  function automatic region_t ind_region(input logic [AW-1:0] a);
    return a[AW-1] ? RG_UPPER : RG_LOWER;
  endfunction

  // RAM byte holding bit number b (b below 80H).
  function automatic logic [IW-1:0] bit_ram_byte(input logic [AW-1:0] b);
    return BIT_RAM_BASE + IW'(b[IW-1:BP_W]);
  endfunction

  // SFR index holding bit number b (b at 80H or above).
  function automatic logic [IW-1:0] bit_sfr_byte(input logic [AW-1:0] b);
    return {b[IW-1:BP_W], {BP_W{1'b0}}};
  endfunction

  // Location of a banked register in lower RAM.
  function automatic logic [IW-1:0] bank_reg(input logic [BANK_W-1:0] bank,
                                             input logic [RN_W-1:0]   rn);
    return IW'({bank, rn});
  endfunction
endpackage

// File: rtl/idm_bit_map.sv
module idm_bit_map
  import idm_pkg::*;
(
  input  logic [AW-1:0]   bit_addr,
  output region_t         region,
  output logic [IW-1:0]   byte_idx,
  output logic [BP_W-1:0] bit_pos
);
  always_comb begin
    bit_pos = bit_addr[BP_W-1:0];
    if (bit_addr[AW-1]) begin
      region   = RG_SFR;
      byte_idx = bit_sfr_byte(bit_addr);
    end else begin
      region   = RG_LOWER;
      byte_idx = bit_ram_byte(bit_addr);
    end
  end
endmodule

// File: rtl/idm_addr_map.sv
module idm_addr_map
  import idm_pkg::*;
#(
  parameter bit HAS_UPPER = 1'b1
) (
  input  acc_mode_t         mode,
  input  logic [AW-1:0]     addr,
  input  logic [RN_W-1:0]   reg_num,
  input  logic [BANK_W-1:0] bank,
  output region_t           region,
  output logic [IW-1:0]     byte_idx,
  output logic [BP_W-1:0]   bit_pos,
  output logic [PTR_W-1:0]  ptr_idx,
  output logic              invalid
);
  region_t             bm_region;
  logic [IW-1:0]       bm_idx;
  logic [BP_W-1:0]     bm_pos;

  idm_bit_map u_bits (
    .bit_addr (addr),
    .region   (bm_region),
    .byte_idx (bm_idx),
    .bit_pos  (bm_pos)
  );

  always_comb begin
    region   = RG_LOWER;
    byte_idx = addr[IW-1:0];
    bit_pos  = '0;
    unique case (mode)
      AM_DIRECT:   region = addr[AW-1] ? RG_SFR : RG_LOWER;
      AM_INDIRECT: region = ind_region(addr);
      AM_REGISTER: byte_idx = bank_reg(bank, reg_num);
      AM_BIT: begin
        region   = bm_region;
        byte_idx = bm_idx;
        bit_pos  = bm_pos;
      end
      default: ;
    endcase
  end

  assign ptr_idx = {bank, {(RN_W-1){1'b0}}, reg_num[0]};
  assign invalid = (region == RG_UPPER) && !HAS_UPPER;
endmodule

// File: rtl/idm_stack_ptr.sv
module idm_stack_ptr
  import idm_pkg::*;
#(
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          sp_wr,
  input  logic [AW-1:0] sp_din,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] stk_addr
);
  logic [AW-1:0] sp_inc;
  logic [AW-1:0] sp_dec;

  assign sp_inc   = sp + AW'(1);
  assign sp_dec   = sp - AW'(1);
  assign stk_addr = push ? sp_inc : sp;

  always_ff @(posedge clk) begin
    if (!rst_n)     sp <= SP_RESET;
    else if (sp_wr) sp <= sp_din;
    else if (push)  sp <= sp_inc;
    else if (pop)   sp <= sp_dec;
  end

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> sp == $past(sp_din));
  a_r10_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sp_wr) |=> sp == $past(sp) + 8'd1);
  a_r11_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !sp_wr) |=> sp == $past(sp) - 8'd1);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !sp_wr) |=> $stable(sp));
endmodule

// File: rtl/idm_decoder.sv
module idm_decoder
  import idm_pkg::*;
#(
  parameter bit            HAS_UPPER = 1'b1,
  parameter logic [7:0]    SP_RESET  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] acc_mode,
  input  logic [7:0] addr,
  input  logic [2:0] reg_num,
  input  logic [1:0] bank_sel,
  input  logic       push,
  input  logic       pop,
  input  logic       sp_wr,
  input  logic [7:0] sp_din,
  output logic [1:0] region,
  output logic [6:0] byte_idx,
  output logic [2:0] bit_pos,
  output logic [4:0] ptr_idx,
  output logic       invalid,
  output logic [7:0] sp,
  output logic [1:0] stk_region,
  output logic [6:0] stk_idx,
  output logic       stk_invalid
);
  region_t       dec_region;
  region_t       stk_reg_e;
  logic [AW-1:0] stk_addr;

  idm_addr_map #(.HAS_UPPER(HAS_UPPER)) u_map (
    .mode     (acc_mode_t'(acc_mode)),
    .addr     (addr),
    .reg_num  (reg_num),
    .bank     (bank_sel),
    .region   (dec_region),
    .byte_idx (byte_idx),
    .bit_pos  (bit_pos),
    .ptr_idx  (ptr_idx),
    .invalid  (invalid)
  );

  idm_stack_ptr #(.SP_RESET(SP_RESET)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .sp_wr    (sp_wr),
    .sp_din   (sp_din),
    .sp       (sp),
    .stk_addr (stk_addr)
  );

  assign stk_reg_e   = ind_region(stk_addr);
  assign stk_region  = stk_reg_e;
  assign stk_idx     = stk_addr[IW-1:0];
  assign stk_invalid = (stk_reg_e == RG_UPPER) && !HAS_UPPER;
  assign region      = dec_region;

  a_r2_indirect_not_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'd1) |-> region != 2'd2);
  a_r3_invalid_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (region == 2'd1) && !HAS_UPPER);
  a_r4_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'd2) |-> (region == 2'd0) && (byte_idx < 7'h20));
  a_r7_sfr_bit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode == 2'd3 && addr[7]) |-> (region == 2'd2) && (byte_idx[2:0] == 3'd0));
  a_r8_bitpos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode != 2'd3) |-> bit_pos == 3'd0);
  a_r12_stack_not_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    stk_region != 2'd2);
endmodule

// File: tb/idm_decoder_test.sv
module idm_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] acc_mode = '0;
  logic [7:0] addr = '0;
  logic [2:0] reg_num = '0;
  logic [1:0] bank_sel = '0;
  logic       push = 1'b0, pop = 1'b0, sp_wr = 1'b0;
  logic [7:0] sp_din = '0;

  logic [1:0] region,  region_n;
  logic [6:0] byte_idx, byte_idx_n;
  logic [2:0] bit_pos, bit_pos_n;
  logic [4:0] ptr_idx, ptr_idx_n;
  logic       invalid, invalid_n;
  logic [7:0] sp, sp_n;
  logic [1:0] stk_region, stk_region_n;
  logic [6:0] stk_idx, stk_idx_n;
  logic       stk_invalid, stk_invalid_n;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  idm_decoder #(.HAS_UPPER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .addr(addr),
    .reg_num(reg_num), .bank_sel(bank_sel), .push(push), .pop(pop),
    .sp_wr(sp_wr), .sp_din(sp_din), .region(region), .byte_idx(byte_idx),
    .bit_pos(bit_pos), .ptr_idx(ptr_idx), .invalid(invalid), .sp(sp),
    .stk_region(stk_region), .stk_idx(stk_idx), .stk_invalid(stk_invalid));

  idm_decoder #(.HAS_UPPER(1'b0)) uut_noup (
    .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .addr(addr),
    .reg_num(reg_num), .bank_sel(bank_sel), .push(push), .pop(pop),
    .sp_wr(sp_wr), .sp_din(sp_din), .region(region_n), .byte_idx(byte_idx_n),
    .bit_pos(bit_pos_n), .ptr_idx(ptr_idx_n), .invalid(invalid_n), .sp(sp_n),
    .stk_region(stk_region_n), .stk_idx(stk_idx_n), .stk_invalid(stk_invalid_n));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (mode %0d addr %0h bank %0d reg %0d)",
               req, act, exp, acc_mode, addr, bank_sel, reg_num);
    end
  endtask

  // Expected stack decode for a given stack address (R12).
  task automatic chk_stack(input string req, input int sa);
    chk({req, "/R12 region"}, stk_region, sa >= 128 ? 1 : 0);
    chk({req, "/R12 index"}, stk_idx, sa % 128);
    chk({req, "/R12 inv up"}, stk_invalid, 0);
    chk({req, "/R12 inv noup"}, stk_invalid_n, sa >= 128 ? 1 : 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset sp", sp, 8'h07);
    chk("R9 reset sp noup", sp_n, 8'h07);

    // Exhaustive decode sweep.
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bk = 0; bk < 4; bk++) begin
          for (int r = 0; r < 8; r++) begin
            int er, ei, ep, einv;
            acc_mode = 2'(m); addr = 8'(a); bank_sel = 2'(bk); reg_num = 3'(r);
            #1;
            ep = 0;
            case (m)
              0: begin er = (a >= 128) ? 2 : 0; ei = a % 128; end
              1: begin er = (a >= 128) ? 1 : 0; ei = a % 128; end
              2: begin er = 0; ei = bk * 8 + r; end
              default: begin
                ep = a % 8;
                if (a < 128) begin er = 0; ei = 32 + a / 8; end
                else begin er = 2; ei = (a / 8) * 8 - 128; end
              end
            endcase
            einv = (er == 1) ? 1 : 0;
            case (m)
              0: begin chk("R1 region", region, er); chk("R1 index", byte_idx, ei); end
              1: begin chk("R2 region", region, er); chk("R2 index", byte_idx, ei);
                       chk("R5 pointer", ptr_idx, bk * 8 + (r % 2)); end
              2: begin chk("R4 region", region, er); chk("R4 index", byte_idx, ei); end
              default: begin
                if (a < 128) begin chk("R6 region", region, er); chk("R6 index", byte_idx, ei); end
                else begin chk("R7 region", region, er); chk("R7 index", byte_idx, ei); end
              end
            endcase
            chk("R8 bit_pos", bit_pos, ep);
            chk("R3 invalid with upper", invalid, 0);
            chk("R3 invalid without upper", invalid_n, einv);
            chk("R1 noup region", region_n, er);
            chk("R1 noup index", byte_idx_n, ei);
          end
        end
      end
    end
    acc_mode = '0; addr = '0;

    // Stack: push from reset value.
    @(negedge clk);
    push = 1'b1; #1;
    chk_stack("R10 push from 07", 8'h08);
    @(negedge clk);
    push = 1'b0; #1;
    chk("R10 sp after push", sp, 8'h08);
    chk_stack("R11 idle", 8'h08);

    // Pop reads at sp, then decrements.
    pop = 1'b1; #1;
    chk_stack("R11 pop at 08", 8'h08);
    @(negedge clk);
    pop = 1'b0; #1;
    chk("R11 sp after pop", sp, 8'h07);

    // Load 7F, push crosses into upper RAM.
    sp_wr = 1'b1; sp_din = 8'h7F;
    @(negedge clk);
    sp_wr = 1'b0; #1;
    chk("R9 load 7F", sp, 8'h7F);
    push = 1'b1; #1;
    chk_stack("R10 push 7F->80", 8'h80);
    @(negedge clk);
    push = 1'b0; #1;
    chk("R10 sp 80", sp_n, 8'h80);
    pop = 1'b1; #1;
    chk_stack("R11 pop at 80", 8'h80);
    @(negedge clk);
    pop = 1'b0; #1;
    chk("R11 sp 7F", sp, 8'h7F);

    // Wrap FF -> 00.
    sp_wr = 1'b1; sp_din = 8'hFF;
    @(negedge clk);
    sp_wr = 1'b0; push = 1'b1; #1;
    chk_stack("R10 push wrap", 8'h00);
    @(negedge clk);
    push = 1'b0; #1;
    chk("R10 sp wrapped", sp, 8'h00);

    // Pop wrap 00 -> FF.
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0; #1;
    chk("R11 pop wrap", sp, 8'hFF);

    // Push and pop together: push wins.
    sp_wr = 1'b1; sp_din = 8'h30;
    @(negedge clk);
    sp_wr = 1'b0; push = 1'b1; pop = 1'b1; #1;
    chk_stack("R13 both addr", 8'h31);
    @(negedge clk);
    push = 1'b0; pop = 1'b0; #1;
    chk("R13 both sp", sp, 8'h31);

    // Load has priority over push/pop.
    sp_wr = 1'b1; sp_din = 8'h55; push = 1'b1;
    @(negedge clk);
    sp_wr = 1'b0; push = 1'b0; #1;
    chk("R9 load over push", sp, 8'h55);
    sp_wr = 1'b1; sp_din = 8'hA0; pop = 1'b1;
    @(negedge clk);
    sp_wr = 1'b0; pop = 1'b0; #1;
    chk("R9 load over pop", sp, 8'hA0);
    chk_stack("R12 idle at A0", 8'hA0);

    // Reset returns sp to 07.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R9 re-reset", sp, 8'h07);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule